// File: doc/BRIEF.md
# Triple-Buffered Serial Word Receiver

This block takes a serial bit stream on a data input and turns it into parallel words for a host. The bit clock reaches it as an ordinary level, and its sampling edge is chosen by a polarity input. A frame-sync pulse starts each word, and the first bit is taken on that same sample. Word length is selected per word from six sizes between 8 and 32 bits.

A finished word moves through three stages. The first is a shift stage. The second is a holding buffer. The third is a host-visible data register, split into an upper and a lower 16-bit half. A word moves forward only when the next stage is free. A host read of the lower half frees the data register, and the buffer then advances into it. For words wider than 16 bits, the host must read the upper half first. A ready flag shows that the data register holds an unread word. An overrun flag records a word that was lost because both later stages were full.

Top module: `tribuf_serial_rx`

## Requirements
- R1: `wlen_sel` chooses the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24 and 5 gives 32. Words of 20 bits or more are "wide".
- R2: With `rx_pol`=0, bits are sampled where `rx_clk` rises. With `rx_pol`=1, they are sampled where it falls. No bit is taken at any other time.
- R3: If `rx_fsync` is high on a sample while no word is in progress, that sample captures the first bit of a new word (zero data delay). `rx_fsync` has no effect while a word is in progress.
- R4: Bits arrive most significant first. For a wide word, `data_lo` holds bits 15..0, and `data_hi` holds the bits above 15, right-justified and zero-filled.
- R5: For a word of 16 bits or fewer, `data_lo` holds the word right-justified and zero-filled. `data_hi` keeps its earlier value.
- R6: A completed word enters the buffer only if the buffer is empty, or is emptying in that same cycle. The buffer moves into the data register only while `ready` is low.
- R7: `ready` rises when the data register is loaded. It falls only on an accepted lower-half read (`rd_lo` high while `ready` is high).
- R8: For a wide word, `rd_lo` is ignored unless `rd_hi` was pulsed earlier for that word or is high in the same cycle. For narrow words, `rd_lo` alone is accepted.
- R9: If a word completes while both the buffer and the data register are full, that word is dropped and `overrun` is set. The words already held are kept. An accepted lower-half read clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk | input | 1 | Serial bit clock, as a level |
| rx_pol | input | 1 | Sampling edge select: 0 rising, 1 falling |
| rx_fsync | input | 1 | Frame-sync marking the first bit of a word |
| rx_data | input | 1 | Serial data |
| wlen_sel | input | 3 | Word length code |
| rd_hi | input | 1 | Host read strobe for the upper half |
| rd_lo | input | 1 | Host read strobe for the lower half |
| data_hi | output | 16 | Upper half of the data register |
| data_lo | output | 16 | Lower half of the data register |
| ready | output | 1 | Data register holds an unread word |
| overrun | output | 1 | A completed word was dropped |

## Verification
The last bit of a word is sampled in the clock where the active edge appears. The done pulse follows one cycle later, the buffer loads a cycle after that, and `ready` with the new data is visible in the third cycle after the sample. The bench holds each bit level for two clocks after the edge and then waits three more clocks before it samples. Every observation therefore falls after the result is due.

After a read strobe, `ready` falls on the next edge, and any buffered word advances one edge after that. The bench checks `ready` and the data three cycles after a read. All outputs are sampled on the falling clock edge.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int HALF_W = 16;
    localparam int CNT_W  = 6;
    localparam int CODE_W = 3;

    typedef struct packed {
        logic              wide;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } srx_word_t;

    function automatic logic [CNT_W-1:0] wlen_bits(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return CNT_W'(8);
            3'd1:    return CNT_W'(12);
            3'd2:    return CNT_W'(16);
            3'd3:    return CNT_W'(20);
            3'd4:    return CNT_W'(24);
            3'd5:    return CNT_W'(32);
            default: return CNT_W'(8);
        endcase
    endfunction

    function automatic logic wlen_wide(input logic [CODE_W-1:0] code);
        return wlen_bits(code) > CNT_W'(HALF_W);
    endfunction
endpackage

// File: rtl/srx_edge_det.sv
module srx_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic pol,
    output logic sample
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sclk;
    end

    always_comb begin
        if (pol) sample = prev_q & ~sclk;
        else     sample = ~prev_q & sclk;
    end
endmodule

// File: rtl/srx_shift.sv
module srx_shift
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              fsync,
    input  logic              din,
    input  logic [CODE_W-1:0] code,
    output logic              done,
    output srx_word_t         word
);
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  bits_q;
    logic              wide_q;
    logic [HALF_W-1:0] sh_hi_q;
    logic [HALF_W-1:0] sh_lo_q;
    logic [CNT_W-1:0]  cnt_nx;

    assign cnt_nx = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            bits_q  <= '0;
            wide_q  <= 1'b0;
            sh_hi_q <= '0;
            sh_lo_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (sample) begin
                if (!busy_q && fsync) begin
                    busy_q  <= 1'b1;
                    cnt_q   <= CNT_W'(1);
                    bits_q  <= wlen_bits(code);
                    wide_q  <= wlen_wide(code);
                    sh_lo_q <= {{(HALF_W-1){1'b0}}, din};
                    if (wlen_wide(code)) sh_hi_q <= '0;
                end else if (busy_q) begin
                    sh_lo_q <= {sh_lo_q[HALF_W-2:0], din};
                    if (wide_q) sh_hi_q <= {sh_hi_q[HALF_W-2:0], sh_lo_q[HALF_W-1]};
                    cnt_q <= cnt_nx;
                    if (cnt_nx == bits_q) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

    assign word = '{wide: wide_q, hi: sh_hi_q, lo: sh_lo_q};

    // R2: the shift contents move only on a sample
    a_r2_shift_on_sample: assert property (@(posedge clk) disable iff (rst)
        busy_q && !sample |=> $stable(sh_lo_q) && $stable(sh_hi_q));
    // R3: an active word keeps its bit count within the selected length
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q != '0) && (cnt_q < bits_q));
    // R5: narrow words never shift the upper half
    a_r5_narrow_hi_still: assert property (@(posedge clk) disable iff (rst)
        busy_q && !wide_q |=> $stable(sh_hi_q));
endmodule

// File: rtl/srx_handoff.sv
module srx_handoff
    import srx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      done,
    input  srx_word_t word,
    input  logic      rd_hi,
    input  logic      rd_lo,
    output srx_word_t drr,
    output logic      ready,
    output logic      overrun
);
    srx_word_t buf_q;
    logic      buf_full_q;
    logic      drr_full_q;
    logic      hi_seen_q;
    logic      ovr_q;
    logic      lo_ok;
    logic      move;

    assign lo_ok = drr_full_q & rd_lo & (~drr.wide | hi_seen_q | rd_hi);
    assign move  = buf_full_q & ~drr_full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q      <= '0;
            buf_full_q <= 1'b0;
            drr        <= '0;
            drr_full_q <= 1'b0;
            hi_seen_q  <= 1'b0;
            ovr_q      <= 1'b0;
        end else begin
            if (lo_ok) begin
                drr_full_q <= 1'b0;
                hi_seen_q  <= 1'b0;
                ovr_q      <= 1'b0;
            end else if (drr_full_q && rd_hi && drr.wide) begin
                hi_seen_q <= 1'b1;
            end
            if (move) begin
                drr_full_q <= 1'b1;
                hi_seen_q  <= 1'b0;
                drr.wide   <= buf_q.wide;
                drr.lo     <= buf_q.lo;
                if (buf_q.wide) drr.hi <= buf_q.hi;
                buf_full_q <= 1'b0;
            end
            if (done) begin
                if (!buf_full_q || move) begin
                    buf_full_q <= 1'b1;
                    buf_q.wide <= word.wide;
                    buf_q.lo   <= word.lo;
                    if (word.wide) buf_q.hi <= word.hi;
                end else begin
                    ovr_q <= 1'b1;
                end
            end
        end
    end

    assign ready   = drr_full_q;
    assign overrun = ovr_q;

    // R7: ready only falls after a lower-half read
    a_r7_ready_fall_needs_read: assert property (@(posedge clk) disable iff (rst)
        $fell(drr_full_q) |-> $past(rd_lo));
    // R6: a full data register holds its content without a read
    a_r6_drr_hold: assert property (@(posedge clk) disable iff (rst)
        drr_full_q && !rd_lo |=> drr_full_q && $stable(drr));
    // R6: the buffer cannot advance while the data register is full
    a_r6_buf_hold: assert property (@(posedge clk) disable iff (rst)
        buf_full_q && drr_full_q |=> buf_full_q && $stable(buf_q));
    // R9: a word completing into full stages raises overrun
    a_r9_overrun_on_full: assert property (@(posedge clk) disable iff (rst)
        done && buf_full_q && drr_full_q && !rd_lo |=> ovr_q);
    // R5: loading a narrow word keeps the upper data half
    a_r5_drr_hi_kept: assert property (@(posedge clk) disable iff (rst)
        move && !buf_q.wide |=> $stable(drr.hi));
endmodule

// File: rtl/tribuf_serial_rx.sv
module tribuf_serial_rx
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_clk,
    input  logic              rx_pol,
    input  logic              rx_fsync,
    input  logic              rx_data,
    input  logic [CODE_W-1:0] wlen_sel,
    input  logic              rd_hi,
    input  logic              rd_lo,
    output logic [HALF_W-1:0] data_hi,
    output logic [HALF_W-1:0] data_lo,
    output logic              ready,
    output logic              overrun
);
    logic      sample;
    logic      done;
    srx_word_t sh_word;
    srx_word_t drr;

    srx_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk   (rx_clk),
        .pol    (rx_pol),
        .sample (sample)
    );

    srx_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .sample (sample),
        .fsync  (rx_fsync),
        .din    (rx_data),
        .code   (wlen_sel),
        .done   (done),
        .word   (sh_word)
    );

    srx_handoff u_hand (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .word    (sh_word),
        .rd_hi   (rd_hi),
        .rd_lo   (rd_lo),
        .drr     (drr),
        .ready   (ready),
        .overrun (overrun)
    );

    assign data_hi = drr.hi;
    assign data_lo = drr.lo;
endmodule

// File: tb/tribuf_serial_rx_tb_top.sv
module tribuf_serial_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_clk = 1'b0;
    logic        rx_pol = 1'b0;
    logic        rx_fsync = 1'b0;
    logic        rx_data = 1'b0;
    logic [2:0]  wlen_sel = 3'd0;
    logic        rd_hi = 1'b0;
    logic        rd_lo = 1'b0;
    logic [15:0] data_hi;
    logic [15:0] data_lo;
    logic        ready;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    logic [15:0] last_hi = 16'h0;

    always #5 clk = ~clk;

    tribuf_serial_rx dut_i (
        .clk(clk), .rst(rst), .rx_clk(rx_clk), .rx_pol(rx_pol),
        .rx_fsync(rx_fsync), .rx_data(rx_data), .wlen_sel(wlen_sel),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .data_hi(data_hi), .data_lo(data_lo),
        .ready(ready), .overrun(overrun)
    );

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;   3'd1: return 12;  3'd2: return 16;
            3'd3: return 20;  3'd4: return 24;  default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // bit level held over the active edge; extra_fs raises frame-sync on a later bit
    task automatic send_word(input logic [2:0] code, input logic pol,
                             input logic [31:0] data, input int extra_fs);
        int n;
        n = len_of(code);
        @(negedge clk);
        rx_pol = pol; rx_clk = pol; wlen_sel = code;
        cyc(2);
        for (int i = n - 1; i >= 0; i--) begin
            rx_data  = data[i];
            rx_fsync = (i == n - 1) || (i == extra_fs);
            rx_clk   = pol;
            cyc(2);
            rx_clk   = ~pol;
            cyc(2);
        end
        rx_fsync = 1'b0;
        rx_clk   = pol;
        cyc(3);
    endtask

    task automatic read_word(input logic hi_first);
        @(negedge clk);
        if (hi_first) begin
            rd_hi = 1'b1; @(negedge clk); rd_hi = 1'b0;
        end
        rd_lo = 1'b1; @(negedge clk); rd_lo = 1'b0;
        cyc(3);
    endtask

    task automatic expect_word(input string req, input logic [2:0] code, input logic [31:0] data);
        check(req, {31'b0, ready}, 32'h1);
        check(req, {16'b0, data_lo}, {16'b0, data[15:0]});
        if (len_of(code) > 16) begin
            check(req, {16'b0, data_hi}, {16'b0, data[31:16]});
            last_hi = data[31:16];
        end else begin
            check(req, {16'b0, data_hi}, {16'b0, last_hi});
        end
    endtask

    initial begin
        cyc(200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] d, w1, w2, w3;
        logic [2:0]  c;
        logic        p;
        void'($urandom(32'd4242));
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R7 reset ready", {31'b0, ready}, 0);
        check("R9 reset overrun", {31'b0, overrun}, 0);
        check("R4 reset data", {data_hi, data_lo}, 0);

        // R2: edges with frame-sync low capture nothing
        for (int i = 0; i < 6; i++) begin rx_clk = ~rx_clk; cyc(2); end
        rx_clk = 1'b0; cyc(6);
        check("R3 no frame no word", {31'b0, ready}, 0);

        // R1 R4 R5: every length code, both polarities
        for (int k = 0; k < 12; k++) begin
            c = 3'(k % 6); p = 1'(k / 6);
            d = $urandom() & mask_of(len_of(c));
            send_word(c, p, d, -1);
            expect_word("R1 length code", c, d);
            read_word(1'b1);
            check("R7 cleared by read", {31'b0, ready}, 0);
        end

        // random words; some raise frame-sync mid-word (R3 ignored)
        for (int k = 0; k < 40; k++) begin
            c = 3'($urandom() % 6); p = 1'($urandom() % 2);
            d = $urandom() & mask_of(len_of(c));
            send_word(c, p, d, ($urandom() % 2) ? 3 : -1);
            expect_word("R3 R4 random word", c, d);
            read_word(1'b1);
            check("R7 random read", {31'b0, ready}, 0);
        end

        // R5: narrow word after a wide one keeps data_hi
        send_word(3'd5, 1'b0, 32'hA5C3_0F1E, -1);
        expect_word("R4 wide", 3'd5, 32'hA5C3_0F1E);
        read_word(1'b1);
        send_word(3'd0, 1'b1, 32'h0000_009B, -1);
        expect_word("R5 narrow keeps hi", 3'd0, 32'h0000_009B);
        check("R5 hi held", {16'b0, data_hi}, 32'h0000_A5C3);
        read_word(1'b0);
        check("R8 narrow lo-only read", {31'b0, ready}, 0);

        // R8: lo-only read of a wide word is ignored
        send_word(3'd3, 1'b0, 32'h000B_1234, -1);
        read_word(1'b0);
        check("R8 lo without hi ignored", {31'b0, ready}, 1);
        check("R8 data intact", {16'b0, data_lo}, 32'h0000_1234);
        read_word(1'b1);
        check("R8 hi then lo accepted", {31'b0, ready}, 0);
        last_hi = 16'h000B;

        // R6 R9: three words without reading
        w1 = 32'h0000_1111; w2 = 32'h0000_2222; w3 = 32'h0000_3333;
        send_word(3'd2, 1'b0, w1, -1);
        send_word(3'd2, 1'b0, w2, -1);
        check("R6 first stays in data reg", {16'b0, data_lo}, w1);
        check("R9 no overrun yet", {31'b0, overrun}, 0);
        send_word(3'd2, 1'b0, w3, -1);
        check("R9 overrun set", {31'b0, overrun}, 1);
        check("R9 held word kept", {16'b0, data_lo}, w1);
        read_word(1'b0);
        check("R9 overrun cleared", {31'b0, overrun}, 0);
        check("R6 buffer advances", {16'b0, data_lo}, w2);
        check("R7 ready after advance", {31'b0, ready}, 1);
        read_word(1'b0);
        check("R9 third word dropped", {31'b0, ready}, 0);
        check("R9 data still second", {16'b0, data_lo}, w2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule